// File: doc/BRIEF.md
# LCD Timing-Generator Backlight Register Slave

This block is a serial-peripheral slave that sits beside an LCD timing generator. A host streams 8-bit command words to it, most significant bit first. Each word names one of eight 5-bit registers and carries the value to store there. Two of these registers act on the outputs. The phase register selects the display resolution mode. The duty register sets the low five bits of the backlight brightness.

The sixth brightness bit does not come from the serial port. It comes from a discrete dimming input: that bit reads 1 while the input is low and 0 while it is high. A second discrete input powers the backlight. The backlight counts as lit only while power is present and the 6-bit level is non-zero. A one-cycle change pulse marks each real change of the level while power is on, so that a downstream PWM stage can reload.

The serial pins and the two discrete inputs are sampled in the block clock domain through synchronizers. The receive state machine has three states:
- ST_IDLE: waiting for chip select.
- ST_SHIFT: collecting bits on rising serial-clock edges.
- ST_APPLY: a single cycle in which the finished word is written.

Its transitions are:
- idle-to-shift: chip select asserted.
- shift-to-apply: the eighth bit has arrived.
- shift-to-idle: chip select dropped, and any partial word is discarded.
- apply-to-shift: chip select still asserted, so another word can follow.
- apply-to-idle: chip select released.

Top module: `tlcd_bl_slave`

## Requirements
- R1: After reset the outputs are as follows: `bl_level` is 0x20, `bl_on` is 0, `bl_chg` is 0 and `qvga_mode` is 0. All eight registers read 0 through the debug port.
- R2: A word is 8 bits, sampled on rising `spi_sclk` edges while `spi_cs_n` is low, most significant bit first. Bits 7:5 are the register address and bits 4:0 are the data. The word is applied after its eighth bit, and several words may follow one another within one chip-select period.
- R3: A word to address 2 (duty) replaces `bl_level[4:0]` with its data and leaves `bl_level[5]` unchanged.
- R4: `bl_level[5]` is 1 while `bl_dim` is low and 0 while `bl_dim` is high, whatever the power state.
- R5: Bit 0 of the register at address 1 (phase) drives `qvga_mode`. Value 1 selects the QVGA mode and value 0 selects the VGA mode.
- R6: `bl_chg` pulses for one cycle, in the cycle in which `bl_level` takes a new value, only while `bl_pwr` is high and only when the value actually differs. Writing the same value, changing power, or changing the level while power is off gives no pulse.
- R7: `bl_on` is high exactly when `bl_pwr` is high and `bl_level` is non-zero.
- R8: `spi_miso` is always 0.
- R9: Addresses 0 and 3 to 7 store their data, which `dbg_data` returns when `dbg_addr` selects them, and have no effect on `bl_level` or `qvga_mode`.
- R10: If `spi_cs_n` rises before the eighth bit of a word, the partial word is dropped. The next word starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, held at 0 |
| bl_dim | input | 1 | Dimming input; a high level clears brightness bit 5 |
| bl_pwr | input | 1 | Backlight power enable |
| dbg_addr | input | 3 | Debug register select |
| dbg_data | output | 5 | Contents of the selected register |
| bl_level | output | 6 | Backlight brightness, 0 to 63 |
| bl_on | output | 1 | Backlight lit |
| bl_chg | output | 1 | One-cycle pulse on a powered brightness change |
| qvga_mode | output | 1 | 1 selects the QVGA mode, 0 the VGA mode |

## Verification
The following properties are checked on every cycle:
- `spi_miso` stays low.
- The apply state lasts one cycle.
- The low brightness bits move only in the cycle after a duty write.
- The mode output moves only after a phase write.
- Every change pulse accompanies a real change of `bl_level`.

The bench scenarios are the only way to show the rest. These include the exact values that serial words and the dimming input produce, the absence of a pulse for unpowered or identical updates, the dropping of a partial word, several words within one chip-select period, and the storing of the inert registers.

// File: rtl/tlcd_pkg.sv
package tlcd_pkg;
    localparam int WORD_W     = 8;
    localparam int ADDR_PHASE = 1;
    localparam int ADDR_DUTY  = 2;
    localparam int MODE_BIT   = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } rx_state_t;
endpackage

// File: rtl/tlcd_sync.sv
module tlcd_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tlcd_spi_rx.sv
module tlcd_spi_rx
    import tlcd_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    output logic          word_vld,
    output logic [WW-1:0] word,
    output rx_state_t     state
);
    localparam int CNT_W = $clog2(WW);

    rx_state_t        state_q, state_n;
    logic             sclk_d;
    logic [CNT_W-1:0] cnt;
    logic [WW-1:0]    sh;
    logic             rise, active, last_bit;

    assign rise     = sclk_s & ~sclk_d;
    assign active   = ~cs_n_s;
    assign last_bit = rise && (cnt == CNT_W'(WW - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (active) state_n = ST_SHIFT;
            ST_SHIFT: begin
                if (!active)       state_n = ST_IDLE;
                else if (last_bit) state_n = ST_APPLY;
            end
            ST_APPLY: state_n = active ? ST_SHIFT : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // bit shifter and counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state_q == ST_SHIFT && active) begin
                if (rise) begin
                    sh  <= {sh[WW-2:0], mosi_s};
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        word_vld = (state_q == ST_APPLY);
        word     = sh;
        state    = state_q;
    end
endmodule

// File: rtl/tlcd_regfile.sv
module tlcd_regfile
    import tlcd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mode_bit
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data  = regs[rd_addr];
    assign mode_bit = regs[ADDR_PHASE][MODE_BIT];
endmodule

// File: rtl/tlcd_backlight.sv
module tlcd_backlight
    import tlcd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dim_s,
    input  logic              pwr_s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W:0]   level,
    output logic              lit,
    output logic              chg
);
    localparam int               LVL_W   = DATA_W + 1;
    localparam logic [LVL_W-1:0] LVL_RST = {1'b1, {DATA_W{1'b0}}};

    logic [LVL_W-1:0] lvl_q, lvl_n;
    logic             chg_q, duty_wr;

    assign duty_wr = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY));
    assign lvl_n   = {~dim_s, duty_wr ? wr_data : lvl_q[DATA_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LVL_RST;
            chg_q <= 1'b0;
        end else begin
            lvl_q <= lvl_n;
            chg_q <= pwr_s && (lvl_n != lvl_q);
        end
    end

    assign level = lvl_q;
    assign lit   = pwr_s && (lvl_q != '0);
    assign chg   = chg_q;
endmodule

// File: rtl/tlcd_bl_slave.sv
module tlcd_bl_slave
    import tlcd_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              bl_dim,
    input  logic              bl_pwr,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic [DATA_W:0]   bl_level,
    output logic              bl_on,
    output logic              bl_chg,
    output logic              qvga_mode
);
    localparam int WW = ADDR_W + DATA_W;

    logic [2:0]        spi_s;
    logic [1:0]        bl_s;
    logic              wr_en;
    logic [WW-1:0]     rx_word;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    rx_state_t         rx_state;

    tlcd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
        .clk(clk), .rst(rst),
        .d({spi_sclk, spi_cs_n, spi_mosi}), .q(spi_s)
    );

    tlcd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_bl_sync (
        .clk(clk), .rst(rst),
        .d({bl_dim, bl_pwr}), .q(bl_s)
    );

    tlcd_spi_rx #(.WW(WW)) u_rx (
        .clk(clk), .rst(rst),
        .sclk_s(spi_s[2]), .cs_n_s(spi_s[1]), .mosi_s(spi_s[0]),
        .word_vld(wr_en), .word(rx_word), .state(rx_state)
    );

    assign wr_addr = rx_word[WW-1:DATA_W];
    assign wr_data = rx_word[DATA_W-1:0];

    tlcd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(dbg_addr), .rd_data(dbg_data), .mode_bit(qvga_mode)
    );

    tlcd_backlight #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bl (
        .clk(clk), .rst(rst),
        .dim_s(bl_s[1]), .pwr_s(bl_s[0]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .level(bl_level), .lit(bl_on), .chg(bl_chg)
    );

    assign spi_miso = 1'b0;
endmodule

// File: rtl/tlcd_bl_checker.sv
module tlcd_bl_checker
    import tlcd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_miso,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W:0]   bl_level,
    input logic              bl_chg,
    input logic              qvga_mode,
    input rx_state_t         rx_state
);
    logic duty_wr, phase_wr;
    assign duty_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY));
    assign phase_wr = wr_en && (wr_addr == ADDR_W'(ADDR_PHASE));

    p_miso_low_r8: assert property (@(posedge clk) disable iff (rst)
        spi_miso == 1'b0);

    p_apply_once_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_state == ST_APPLY) |=> (rx_state != ST_APPLY));

    p_low_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(duty_wr) |-> (bl_level[DATA_W-1:0] == $past(bl_level[DATA_W-1:0])));

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(phase_wr) |-> $stable(qvga_mode));

    p_chg_real_r6: assert property (@(posedge clk) disable iff (rst)
        bl_chg |-> (bl_level != $past(bl_level)));
endmodule

bind tlcd_bl_slave tlcd_bl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .spi_miso(spi_miso),
    .wr_en(wr_en), .wr_addr(wr_addr), .bl_level(bl_level),
    .bl_chg(bl_chg), .qvga_mode(qvga_mode), .rx_state(rx_state)
);

// File: tb/tlcd_bl_slave_tb.sv
module tlcd_bl_slave_tb;
    localparam int CLK_T = 10;
    localparam int HALF  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       bl_dim = 1'b0, bl_pwr = 1'b0;
    logic [2:0] dbg_addr = 3'd0;
    logic [4:0] dbg_data;
    logic [5:0] bl_level;
    logic       bl_on, bl_chg, qvga_mode;

    int n_chk = 0, n_bad = 0, miso_bad = 0;
    bit done = 1'b0;
    logic [5:0] exp_q[$];
    logic [5:0] lvl_m = 6'h20;
    logic       pwr_m = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    tlcd_bl_slave u_dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bl_dim(bl_dim),
        .bl_pwr(bl_pwr), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .bl_level(bl_level), .bl_on(bl_on), .bl_chg(bl_chg),
        .qvga_mode(qvga_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // model update: a pulse is expected only when powered and the level differs (R6)
    task automatic model_lvl(input logic [5:0] nv);
        if (pwr_m && nv != lvl_m) exp_q.push_back(nv);
        lvl_m = nv;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] w, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = w[i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_off();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [4:0] d);
        if (a == 3'd2) model_lvl({lvl_m[5], d});
        cs_on();
        spi_bits({a, d}, 8);
        cs_off();
    endtask

    task automatic set_dim(input logic v);
        model_lvl({~v, lvl_m[4:0]});
        bl_dim = v;
        wait_clk(6);
    endtask

    task automatic set_pwr(input logic v);
        pwr_m  = v;
        bl_pwr = v;
        wait_clk(6);
    endtask

    task automatic read_dbg(input logic [2:0] a, input logic [4:0] e, input string tag);
        dbg_addr = a;
        wait_clk(1);
        chk(dbg_data == e, tag, dbg_data, e);
    endtask

    // scoreboard monitor: every change pulse must match the next expected level (R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_miso !== 1'b0) miso_bad++;
            if (bl_chg) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected pulse", bl_level, lvl_m);
                end else begin
                    logic [5:0] e;
                    e = exp_q.pop_front();
                    chk(bl_level == e, "R6 pulse level", bl_level, e);
                end
            end
        end
    end

    initial begin
        #(CLK_T * 150000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R1 reset state
        chk(bl_level == 6'h20, "R1 level", bl_level, 6'h20);
        chk(bl_on == 1'b0, "R1 on", bl_on, 0);
        chk(bl_chg == 1'b0, "R1 chg", bl_chg, 0);
        chk(qvga_mode == 1'b0, "R1 mode", qvga_mode, 0);
        for (int a = 0; a < 8; a++) read_dbg(3'(a), 5'h00, "R1 reg");

        // R7 power on with non-zero level; R6 no pulse from power alone
        set_pwr(1'b1);
        chk(bl_on == 1'b1, "R7 lit", bl_on, 1);

        // R3 duty write keeps bit 5
        write_reg(3'd2, 5'h15);
        chk(bl_level == 6'h35, "R3 duty", bl_level, 6'h35);
        read_dbg(3'd2, 5'h15, "R3 reg");

        // R4 dim input drives bit 5
        set_dim(1'b1);
        chk(bl_level == 6'h15, "R4 dim high", bl_level, 6'h15);
        set_dim(1'b0);
        chk(bl_level == 6'h35, "R4 dim low", bl_level, 6'h35);

        // R6 same value gives no pulse
        write_reg(3'd2, 5'h15);
        chk(bl_level == 6'h35, "R6 same value", bl_level, 6'h35);

        // R7 zero level is dark
        set_dim(1'b1);
        write_reg(3'd2, 5'h00);
        chk(bl_level == 6'h00, "R3 zero", bl_level, 0);
        chk(bl_on == 1'b0, "R7 zero dark", bl_on, 0);

        // R6 unpowered change gives no pulse; R4 still applies
        set_pwr(1'b0);
        set_dim(1'b0);
        chk(bl_level == 6'h20, "R4 unpowered", bl_level, 6'h20);
        chk(bl_on == 1'b0, "R7 unpowered", bl_on, 0);
        set_pwr(1'b1);
        chk(bl_on == 1'b1, "R7 repowered", bl_on, 1);

        // R5 phase bit 0 selects the mode
        write_reg(3'd1, 5'h01);
        chk(qvga_mode == 1'b1, "R5 qvga", qvga_mode, 1);
        write_reg(3'd1, 5'h1E);
        chk(qvga_mode == 1'b0, "R5 vga", qvga_mode, 0);
        write_reg(3'd1, 5'h03);
        chk(qvga_mode == 1'b1, "R5 qvga again", qvga_mode, 1);

        // R9 inert registers
        write_reg(3'd5, 5'h0A);
        write_reg(3'd7, 5'h1F);
        write_reg(3'd0, 5'h11);
        chk(bl_level == 6'h20, "R9 level kept", bl_level, 6'h20);
        chk(qvga_mode == 1'b1, "R9 mode kept", qvga_mode, 1);
        read_dbg(3'd5, 5'h0A, "R9 reg5");
        read_dbg(3'd7, 5'h1F, "R9 reg7");
        read_dbg(3'd0, 5'h11, "R9 reg0");

        // R2 two words in one chip-select period
        model_lvl({lvl_m[5], 5'h07});
        cs_on();
        spi_bits({3'd2, 5'h07}, 8);
        wait_clk(HALF);
        spi_bits({3'd6, 5'h09}, 8);
        cs_off();
        chk(bl_level == 6'h27, "R2 first word", bl_level, 6'h27);
        read_dbg(3'd6, 5'h09, "R2 second word");

        // R10 partial word dropped
        cs_on();
        spi_bits({3'd2, 5'h1F}, 5);
        cs_off();
        write_reg(3'd4, 5'h03);
        chk(bl_level == 6'h27, "R10 level kept", bl_level, 6'h27);
        read_dbg(3'd4, 5'h03, "R10 realigned");
        read_dbg(3'd2, 5'h07, "R10 duty kept");

        wait_clk(4);
        chk(miso_bad == 0, "R8 miso", miso_bad, 0);
        chk(exp_q.size() == 0, "R6 missing pulses", exp_q.size(), 0);
        summary();
    end
endmodule